// File: doc/BRIEF.md
# Single-Wire LED Pixel Stream Receiver

This block listens to a sampled single-wire, return-to-zero LED data line and turns it back into pixel colour words. Every bit time opens with a rising edge; the falling edge that follows closes the bit's high phase. The value of a bit is settled one bit late, when the next rising edge arrives, by comparing the high time with the measured bit period. A low level longer than the reset interval ends a frame. When that happens, the block resolves the last bit using a substitute threshold, drops any incomplete pixel and clears its bit-timing state.

Bits are packed most significant first. A pixel is 24 bits in three-channel mode and 32 bits in four-channel mode. The channels arrive as green, red, blue and then white. The output word is reordered to red, green, blue, with white in the lowest byte. The line passes through a synchroniser. All intervals are derived from the clock frequency parameter, and the interval counters saturate.

Top module: `ledstream_rx`

## Requirements
- R1: Before any edge counts, the receiver waits after reset for the synchronised line to be low. A high level present at reset release never produces a bit. A change on `line_in` reaches the outputs three clock cycles later.
- R2: A bit is resolved at the next rising edge. `bit_value` is 1 when twice the high time is strictly greater than the period, measured rising edge to rising edge, and 0 otherwise. The resolution raises `bit_strobe` for one cycle.
- R3: A reset is detected once the line has stayed low, counted from the last falling edge (or from arming), for RST_CYC+1 cycles, where RST_CYC = CLK_HZ·RST_NS/10^9. One low interval gives at most one detection, and a rising edge before that point cancels it.
- R4: The first reset detected after power-up is processed but does not raise `rst_strobe`. Every later reset raises `rst_strobe` for one cycle.
- R5: A bit still pending when a reset is detected is resolved in that same cycle. If the current word already holds bits, the result is 1 when twice the high time is greater than or equal to the period of the previously resolved bit. If the word is empty, the result is 1 when the high time is greater than or equal to FB_CYC = CLK_HZ·FB_NS/10^9.
- R6: With `mode_rgbw`=0 a pixel is 24 bits, and with `mode_rgbw`=1 it is 32 bits. The first bit received is the most significant bit of the raw word.
- R7: In the raw word the channels arrive as green, red, blue, then white. `pix_data` is {8'h00, R, G, B} in three-channel mode and {R, G, B, W} in four-channel mode.
- R8: A detected reset discards the bits of an incomplete pixel. The next pixel is assembled from bit zero.
- R9: `pix_valid` is high for one cycle, in the same cycle as the `bit_strobe` of the pixel's final bit. The next pixel's bits accumulate with no gap.
- R10: An idle low of any length, including one past the counter range, gives exactly one reset detection and no bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_in | input | 1 | Raw data line |
| mode_rgbw | input | 1 | 0: three-channel 24-bit pixels, 1: four-channel 32-bit pixels |
| pix_data | output | 32 | Reordered colour word, held between pixels |
| pix_valid | output | 1 | One-cycle strobe marking a new `pix_data` |
| bit_strobe | output | 1 | One-cycle strobe for each resolved bit |
| bit_value | output | 1 | Value of the most recently resolved bit |
| rst_strobe | output | 1 | One-cycle strobe for each reset after the first |

## Verification
A corrupted period or high-time count shows up as a wrong `bit_value` at the very next rising edge, so a timing fault appears within one bit period. A wrong bit count in the packer shows as `pix_valid` on the wrong strobe or as a shifted `pix_data`, at the next pixel boundary at the latest. A wrong low counter or first-reset flag shows only at the end of the next low interval: as a missing, early, doubled or unwanted `rst_strobe`, or as a mis-thresholded final bit in that same cycle. For this reason the reference comparison runs on every clock, and the directed frames end at exact threshold values.

// File: rtl/ledrx_pkg.sv
package ledrx_pkg;

  localparam int unsigned PIX_BITS_MAX = 32;

  typedef struct packed {
    logic valid;
    logic value;
  } bit_ev_t;

  // raw word: wide -> G[31:24] R[23:16] B[15:8] W[7:0]; narrow -> G[23:16] R[15:8] B[7:0]
  function automatic logic [31:0] swap_channels(input logic [31:0] raw, input logic wide);
    logic [31:0] res;
    if (wide) res = {raw[23:16], raw[31:24], raw[15:8], raw[7:0]};
    else      res = {8'h00, raw[15:8], raw[23:16], raw[7:0]};
    return res;
  endfunction

endpackage

// File: rtl/ledrx_rstsync.sv
module ledrx_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/ledrx_sync.sv
module ledrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic s_line,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign s_line = chain_q[STAGES-1];
  assign rise   = s_line & ~prev_q;
  assign fall   = ~s_line & prev_q;
endmodule

// File: rtl/ledrx_timer.sv
module ledrx_timer
  import ledrx_pkg::*;
#(
  parameter int RST_CYC = 12500,
  parameter int FB_CYC  = 156,
  parameter int CW      = 14
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    s_line,
  input  logic    rise,
  input  logic    fall,
  input  logic    word_empty,
  output bit_ev_t ev,
  output logic    flush,
  output logic    rst_strobe
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] FIRE_AT = CW'(RST_CYC + 1);
  localparam logic [CW-1:0] FB_LIM  = CW'(FB_CYC);

  logic          armed_q, armed_d;
  logic          watch_q, watch_d;
  logic          has_start_q, has_start_d;
  logic          has_mid_q, has_mid_d;
  logic          seen_q, seen_d;
  logic [CW-1:0] per_q, per_d;
  logic [CW-1:0] high_q, high_d;
  logic [CW-1:0] low_q, low_d;
  logic [CW-1:0] lastp_q, lastp_d;
  logic          rst_d;
  logic          rise_ok, fire, val_rise, val_tail;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CNT_MAX) ? v : v + CW'(1);
  endfunction

  always_comb begin
    armed_d     = armed_q;
    watch_d     = watch_q;
    has_start_d = has_start_q;
    has_mid_d   = has_mid_q;
    seen_d      = seen_q;
    per_d       = per_q;
    high_d      = high_q;
    low_d       = low_q;
    lastp_d     = lastp_q;

    rise_ok  = armed_q & rise & has_start_q & has_mid_q;
    val_rise = {high_q, 1'b0} > {1'b0, per_q};
    fire     = armed_q & watch_q & ~rise & (low_q == FIRE_AT);
    val_tail = word_empty ? (high_q >= FB_LIM) : ({high_q, 1'b0} >= {1'b0, lastp_q});

    ev.valid = rise_ok | (fire & has_start_q & has_mid_q);
    ev.value = rise_ok ? val_rise : val_tail;

    if (!armed_q) begin
      if (!s_line) begin
        armed_d = 1'b1;
        watch_d = 1'b1;
        low_d   = CW'(1);
      end
    end else if (rise) begin
      has_start_d = 1'b1;
      has_mid_d   = 1'b0;
      per_d       = CW'(1);
      watch_d     = 1'b0;
      if (rise_ok) lastp_d = per_q;
    end else begin
      per_d = sat_inc(per_q);
      if (fall) begin
        low_d   = CW'(1);
        watch_d = 1'b1;
        if (has_start_q) begin
          high_d    = per_q;
          has_mid_d = 1'b1;
        end
      end else begin
        low_d = sat_inc(low_q);
      end
      if (fire) begin
        has_start_d = 1'b0;
        has_mid_d   = 1'b0;
        watch_d     = 1'b0;
        seen_d      = 1'b1;
      end
    end

    rst_d = fire & seen_q;
  end

  assign flush = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      watch_q     <= 1'b0;
      has_start_q <= 1'b0;
      has_mid_q   <= 1'b0;
      seen_q      <= 1'b0;
      per_q       <= '0;
      high_q      <= '0;
      low_q       <= '0;
      lastp_q     <= '0;
      rst_strobe  <= 1'b0;
    end else begin
      armed_q     <= armed_d;
      watch_q     <= watch_d;
      has_start_q <= has_start_d;
      has_mid_q   <= has_mid_d;
      seen_q      <= seen_d;
      per_q       <= per_d;
      high_q      <= high_d;
      low_q       <= low_d;
      lastp_q     <= lastp_d;
      rst_strobe  <= rst_d;
    end
  end
endmodule

// File: rtl/ledrx_packer.sv
module ledrx_packer
  import ledrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide,
  input  bit_ev_t     ev,
  input  logic        flush,
  output logic        word_empty,
  output logic        bit_strobe,
  output logic        bit_value,
  output logic        pix_valid,
  output logic [31:0] pix_data
);
  localparam int CNTW = $clog2(PIX_BITS_MAX + 1);

  logic [PIX_BITS_MAX-1:0] sh_q, sh_d;
  logic [CNTW-1:0]         cnt_q, cnt_d, need;
  logic                    done;
  logic [31:0]             pix_d;
  logic                    bitv_d;

  always_comb begin
    need   = wide ? CNTW'(32) : CNTW'(24);
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    bitv_d = bit_value;
    if (ev.valid) begin
      sh_d   = {sh_q[PIX_BITS_MAX-2:0], ev.value};
      bitv_d = ev.value;
      done   = (cnt_q + CNTW'(1)) >= need;
      cnt_d  = done ? '0 : cnt_q + CNTW'(1);
    end
    if (flush) cnt_d = '0;
    pix_d = done ? swap_channels(sh_d[31:0], wide) : pix_data;
  end

  assign word_empty = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      bit_strobe <= 1'b0;
      bit_value  <= 1'b0;
      pix_valid  <= 1'b0;
      pix_data   <= '0;
    end else begin
      sh_q       <= sh_d;
      cnt_q      <= cnt_d;
      bit_strobe <= ev.valid;
      bit_value  <= bitv_d;
      pix_valid  <= done;
      pix_data   <= pix_d;
    end
  end
endmodule

// File: rtl/ledstream_rx.sv
module ledstream_rx
  import ledrx_pkg::*;
#(
  parameter int CLK_HZ      = 250_000_000,
  parameter int RST_NS      = 50_000,
  parameter int FB_NS       = 625,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_in,
  input  logic        mode_rgbw,
  output logic [31:0] pix_data,
  output logic        pix_valid,
  output logic        bit_strobe,
  output logic        bit_value,
  output logic        rst_strobe
);
  localparam longint NS_PER_S = 1_000_000_000;
  localparam int RST_CYC = int'((longint'(CLK_HZ) * longint'(RST_NS)) / NS_PER_S);
  localparam int FB_CYC  = int'((longint'(CLK_HZ) * longint'(FB_NS)) / NS_PER_S);
  localparam int CW      = $clog2(RST_CYC + 3);

  logic    rst_n_int;
  logic    s_line, rise, fall;
  logic    word_empty, flush;
  bit_ev_t ev;

  ledrx_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ledrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .din    (line_in),
    .s_line (s_line),
    .rise   (rise),
    .fall   (fall)
  );

  ledrx_timer #(.RST_CYC(RST_CYC), .FB_CYC(FB_CYC), .CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .s_line     (s_line),
    .rise       (rise),
    .fall       (fall),
    .word_empty (word_empty),
    .ev         (ev),
    .flush      (flush),
    .rst_strobe (rst_strobe)
  );

  ledrx_packer u_pack (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wide       (mode_rgbw),
    .ev         (ev),
    .flush      (flush),
    .word_empty (word_empty),
    .bit_strobe (bit_strobe),
    .bit_value  (bit_value),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data)
  );
endmodule

// File: rtl/ledrx_chk.sv
module ledrx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_rgbw,
  input logic        s_line,
  input logic        bit_strobe,
  input logic        pix_valid,
  input logic [31:0] pix_data,
  input logic        rst_strobe
);
  assert_pix_on_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> bit_strobe);

  assert_pix_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  assert_bit_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);

  assert_rst_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_strobe |-> !$past(s_line));

  assert_rst_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_strobe |=> !rst_strobe);

  assert_narrow_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !$past(mode_rgbw)) |-> (pix_data[31:24] == 8'h00));
endmodule

bind ledstream_rx ledrx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_rgbw  (mode_rgbw),
  .s_line     (s_line),
  .bit_strobe (bit_strobe),
  .pix_valid  (pix_valid),
  .pix_data   (pix_data),
  .rst_strobe (rst_strobe)
);

// File: tb/ledstream_rx_tb.sv
module ledstream_rx_tb;
  localparam int CLK_HZ = 250_000_000;
  localparam int RST_NS = 20_000;
  localparam int FB_NS  = 625;
  localparam longint NS_PER_S = 1_000_000_000;
  localparam int RSTC = int'((longint'(CLK_HZ) * longint'(RST_NS)) / NS_PER_S);
  localparam int FBC  = int'((longint'(CLK_HZ) * longint'(FB_NS)) / NS_PER_S);
  localparam int GAP  = RSTC + 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_in;
  logic        mode_rgbw;
  logic [31:0] pix_data;
  logic        pix_valid, bit_strobe, bit_value, rst_strobe;

  always #2 clk = ~clk;

  ledstream_rx #(.CLK_HZ(CLK_HZ), .RST_NS(RST_NS), .FB_NS(FB_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .mode_rgbw(mode_rgbw),
    .pix_data(pix_data), .pix_valid(pix_valid), .bit_strobe(bit_strobe),
    .bit_value(bit_value), .rst_strobe(rst_strobe)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // ---------------- reference model ----------------
  int  mrc, n, ss_t, inv_t, low_t, last_per;
  bit  m_f1, m_s, m_p, armed, watch, has_ss, has_inv, seen;
  bit  bq[$];
  bit  e_bs, e_bv, e_pv, e_rs;
  logic [31:0] e_pd;

  function automatic logic [31:0] mpack(input bit wide);
    logic [7:0] by [4];
    for (int k = 0; k < 4; k++) begin
      by[k] = 8'h00;
      if (k < (wide ? 4 : 3))
        for (int j = 0; j < 8; j++) by[k] = by[k] | (8'(bq[8*k+j]) << (7 - j));
    end
    if (wide) return {by[1], by[0], by[2], by[3]};
    return {8'h00, by[1], by[0], by[2]};
  endfunction

  task automatic mpush(input bit v, input bit wide);
    e_bs = 1'b1;
    e_bv = v;
    bq.push_back(v);
    if (bq.size() == (wide ? 32 : 24)) begin
      e_pv = 1'b1;
      e_pd = mpack(wide);
      bq.delete();
    end
  endtask

  task automatic mreset();
    m_f1 = 1; m_s = 1; m_p = 1; armed = 0; watch = 0; has_ss = 0; has_inv = 0; seen = 0;
    bq.delete(); e_bs = 0; e_bv = 0; e_pv = 0; e_pd = '0; e_rs = 0; n = 0;
    ss_t = 0; inv_t = 0; low_t = 0; last_per = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mrc = 0;
      mreset();
    end else if (mrc < 2) begin
      mrc++;
      mreset();
    end else begin
      bit rise, fall, v;
      int d, per;
      e_bs = 0; e_pv = 0; e_rs = 0;
      rise = m_s && !m_p;
      fall = !m_s && m_p;
      if (!armed) begin
        if (!m_s) begin armed = 1; watch = 1; low_t = n; end
      end else if (rise) begin
        if (has_ss && has_inv) begin
          per = n - ss_t;
          d   = inv_t - ss_t;
          mpush(2 * d > per, mode_rgbw);
          last_per = per;
        end
        has_ss = 1; has_inv = 0; ss_t = n; watch = 0;
      end else begin
        if (fall && has_ss) begin inv_t = n; has_inv = 1; end
        if (fall) begin low_t = n; watch = 1; end
        if (watch && (n - low_t) == RSTC + 1) begin
          if (has_ss && has_inv) begin
            d = inv_t - ss_t;
            v = (bq.size() == 0) ? (d >= FBC) : (2 * d >= last_per);
            mpush(v, mode_rgbw);
          end
          bq.delete();
          has_ss = 0; has_inv = 0; watch = 0;
          e_rs = seen;
          seen = 1;
        end
      end
      m_p = m_s; m_s = m_f1; m_f1 = line_in;
      n++;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!finished) begin
      checks += 3;
      if (bit_strobe !== e_bs || (e_bs && bit_value !== e_bv)) begin
        fails++;
        $display("FAIL R2 bit output t=%0t actual=%b/%b expected=%b/%b",
                 $time, bit_strobe, bit_value, e_bs, e_bv);
      end
      if (pix_valid !== e_pv || (e_pv && pix_data !== e_pd)) begin
        fails++;
        $display("FAIL R9 pixel output t=%0t actual=%b/%h expected=%b/%h",
                 $time, pix_valid, pix_data, e_pv, e_pd);
      end
      if (rst_strobe !== e_rs) begin
        fails++;
        $display("FAIL R3 reset strobe t=%0t actual=%b expected=%b", $time, rst_strobe, e_rs);
      end
    end
  end

  // ---------------- output monitor ----------------
  logic [31:0] got_pix[$];
  int          rst_seen = 0;
  int          nbits = 0;
  bit          last_bit = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_valid) got_pix.push_back(pix_data);
      if (rst_strobe) rst_seen++;
      if (bit_strobe) begin nbits++; last_bit = bit_value; end
    end
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_pix(input string tag, input logic [31:0] exp);
    if (got_pix.size() == 0) begin
      checks++; fails++;
      $display("FAIL %s actual=none expected=%h", tag, exp);
    end else begin
      check_eq(tag, got_pix.pop_front(), exp);
    end
  endtask

  // ---------------- stimulus ----------------
  task automatic hold(input bit v, input int cyc);
    line_in = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send_bit(input bit v);
    hold(1'b1, v ? 80 : 40);
    hold(1'b0, v ? 40 : 80);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic send_rgb(input logic [7:0] g, input logic [7:0] r, input logic [7:0] b);
    send_byte(g); send_byte(r); send_byte(b);
  endtask

  int r0, b0;

  initial begin
    rst_n = 1'b0;
    line_in = 1'b1;
    mode_rgbw = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: line high at release, then idle low: first reset silent (R4)
    hold(1'b1, 100);
    check_eq("R1 no bit before line low", nbits, 0);
    hold(1'b0, GAP);
    check_eq("R4 first reset silent", rst_seen, 0);
    check_eq("R1 no pixel after idle", got_pix.size(), 0);

    // R6 R7: three-channel pixel, final bit closed by reset
    send_rgb(8'h12, 8'h34, 8'h56);
    hold(1'b0, GAP);
    expect_pix("R7 rgb reorder", 32'h0034_1256);
    check_eq("R3 reset after frame", rst_seen, 1);
    check_eq("R6 24 bits counted", nbits, 24);

    // R9: two pixels back to back
    send_rgb(8'hA5, 8'h0F, 8'hF0);
    send_rgb(8'h01, 8'h80, 8'hFF);
    hold(1'b0, GAP);
    expect_pix("R9 first of pair", 32'h000F_A5F0);
    expect_pix("R9 second of pair", 32'h0080_01FF);

    // R6 R7: four-channel pixel
    mode_rgbw = 1'b1;
    send_rgb(8'h11, 8'h22, 8'h33);
    send_byte(8'h44);
    hold(1'b0, GAP);
    expect_pix("R6 rgbw word", 32'h2211_3344);
    mode_rgbw = 1'b0;

    // R8: partial pixel discarded
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    hold(1'b0, GAP);
    check_eq("R8 no pixel from partial", got_pix.size(), 0);
    send_rgb(8'h00, 8'hFF, 8'h00);
    hold(1'b0, GAP);
    expect_pix("R8 clean pixel after discard", 32'h00FF_0000);
    check_eq("R8 only one pixel", got_pix.size(), 0);

    // R5: empty word -> fixed threshold (>=)
    b0 = nbits;
    hold(1'b1, FBC); hold(1'b0, GAP);
    check_eq("R5 fallback at threshold is 1", last_bit, 1);
    hold(1'b1, FBC - 1); hold(1'b0, GAP);
    check_eq("R5 fallback below threshold is 0", last_bit, 0);
    check_eq("R5 two tail bits", nbits - b0, 2);

    // R5: non-empty word -> half previous period (>=)
    send_bit(1'b1);
    hold(1'b1, 60); hold(1'b0, GAP);
    check_eq("R5 half period equal is 1", last_bit, 1);
    send_bit(1'b1);
    hold(1'b1, 59); hold(1'b0, GAP);
    check_eq("R5 below half period is 0", last_bit, 0);
    check_eq("R8 tails leave no pixel", got_pix.size(), 0);

    // R2: strict half at a rising edge
    hold(1'b1, 60); hold(1'b0, 60);
    hold(1'b1, 61); hold(1'b0, 59);
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    send_byte(8'h00); send_byte(8'h00);
    hold(1'b0, GAP);
    expect_pix("R2 equal half is 0, above is 1", 32'h0000_4000);

    // R3: low gap just below reset interval does not reset
    r0 = rst_seen;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    hold(1'b1, 40); hold(1'b0, RSTC - 10);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    send_byte(8'h55); send_byte(8'hAA);
    check_eq("R3 short gap no reset", rst_seen - r0, 0);
    hold(1'b0, GAP);
    expect_pix("R3 pixel spans long gap", 32'h0055_E0AA);

    // R10: idle beyond counter range -> one reset only
    r0 = rst_seen;
    b0 = nbits;
    send_rgb(8'h01, 8'h02, 8'h03);
    hold(1'b0, 3 * RSTC);
    check_eq("R10 one reset on long idle", rst_seen - r0, 1);
    check_eq("R10 no extra bits", nbits - b0, 24);
    expect_pix("R10 pixel before idle", 32'h0002_0103);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule